// File: doc/BRIEF.md
# Task Object Rename and Version Table

This block finds data dependencies between tasks that are decoded one after another in program order. Each task operand names a memory object by address and says whether the task reads or writes it. The block keeps a direct-mapped slot table, indexed by a fold of the object address, that points at the newest live version of each object. Beside it sits a version table whose records carry only metadata: the producing task, a count of outstanding readers, a finished flag and a link to the next version of the same object. No operand data is ever stored.

Operands enter one per cycle through a valid/ready handshake. A read on a live object registers itself as a reader of the newest version and is told whether it must wait for that version's producer. A write allocates a fresh version. When an older version of the object is still live, the write is chained behind it and must wait. This chain resolves anti- and output-dependencies. A version is freed once its producer has reported completion and its reader count is zero. Freeing a chained version sends an unblock message to the next writer. Freeing the newest version of an object removes the object from the slot table.

Top module: `task_obj_renamer`

## Requirements
- R1: After reset `dec_ready` is high, `rsp_valid` and `unb_valid` are low, and no object has a live version.
- R2: The slot of an address is the XOR of its 6-bit chunks taken from bit 0 upward; the top chunk holds only bits 30 and 31. An operand whose slot holds a live entry with a different address sees `dec_ready` low. It is accepted once that entry has been freed.
- R3: A read of an object with no live version returns `rsp_wait`=0 and `rsp_tracked`=0.
- R4: A response appears with `rsp_valid` high in the cycle after acceptance. A read of a live object returns `rsp_tracked`=1 and `rsp_dep_ver` equal to its newest version. It returns `rsp_wait`=1 exactly when that version's producer has not finished.
- R5: A write takes the lowest-numbered free version and returns it in `rsp_new_ver`. If the object already had a live version, the response has `rsp_wait`=1 and `rsp_dep_ver` set to that version. Otherwise it has `rsp_wait`=0.
- R6: An operand accepted in a cycle sees the table updates of every operand accepted earlier, including one accepted in the previous cycle.
- R7: A version is freed once `done_valid` has named it and as many `rdone_valid` pulses have named it as reads were registered on it. A freed version can be allocated again. Freeing an object's newest version makes the object absent.
- R8: Freeing a version that has a successor raises `unb_valid` for one cycle, with `unb_ver` and `unb_task` set to that successor. Successive writers of one object are unblocked in the order they were decoded.
- R9: When all 16 versions are live, writes see `dec_ready` low but reads are still accepted.
- R10: A read sees `dec_ready` low while the newest version of its object already counts 15 readers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Operand offered for decode |
| dec_ready | output | 1 | Operand can be accepted this cycle |
| dec_write | input | 1 | 1 = task writes the object, 0 = task only reads it |
| dec_addr | input | 32 | Object address |
| dec_task | input | 8 | Task identifier of the operand's task |
| rsp_valid | output | 1 | Decode response valid |
| rsp_wait | output | 1 | Operand must wait on `rsp_dep_ver` |
| rsp_tracked | output | 1 | Read registered as a reader of `rsp_dep_ver` |
| rsp_dep_ver | output | 4 | Version depended upon (0 when none) |
| rsp_new_ver | output | 4 | Version created by a write (0 for reads) |
| done_valid | input | 1 | Producer of `done_ver` has finished |
| done_ver | input | 4 | Version whose producer finished |
| rdone_valid | input | 1 | One reader of `rdone_ver` has finished |
| rdone_ver | input | 4 | Version whose reader finished |
| unb_valid | output | 1 | Unblock message valid |
| unb_ver | output | 4 | Version now allowed to proceed |
| unb_task | output | 8 | Producer task of `unb_ver` |

## Verification
The bench uses the package defaults: 64 slots, 16 versions, 4-bit reader counts and 32-bit addresses. With only 16 versions, sixteen writes to distinct objects exhaust the version pool, and fifteen reads saturate a reader count, so both stall conditions are reached cheaply. The 32-bit address makes the two-bit top chunk of the fold matter, and the bench checks it with a conflict between an address that uses only bit 31 and a small address. A table of operand and completion steps covers chained writers, their unblock order, and the reuse of freed versions.

// File: rtl/ort_pkg.sv
package ort_pkg;

    localparam int OBJ_ADDR_W  = 32;
    localparam int TASK_ID_W   = 8;
    localparam int SLOT_BITS   = 6;
    localparam int NUM_SLOTS   = 1 << SLOT_BITS;
    localparam int VER_BITS    = 4;
    localparam int NUM_VERS    = 1 << VER_BITS;
    localparam int RDR_W       = 4;
    localparam int FOLD_CHUNKS = (OBJ_ADDR_W + SLOT_BITS - 1) / SLOT_BITS;

    typedef logic [OBJ_ADDR_W-1:0] obj_addr_t;
    typedef logic [TASK_ID_W-1:0]  task_id_t;
    typedef logic [SLOT_BITS-1:0]  slot_t;
    typedef logic [VER_BITS-1:0]   ver_t;
    typedef logic [RDR_W-1:0]      rdr_t;

    // One slot of the renaming table
    typedef struct packed {
        logic      live;
        obj_addr_t tag;
        ver_t      latest;
    } slot_ent_t;

    // One metadata record of the version table
    typedef struct packed {
        logic     live;
        logic     done;
        logic     has_next;
        ver_t     next;
        slot_t    slot;
        task_id_t producer;
        rdr_t     readers;
    } ver_rec_t;

    // Registered decode answer
    typedef struct packed {
        logic wait_dep;
        logic tracked;
        ver_t dep;
        ver_t new_ver;
    } dec_rsp_t;

    // XOR fold of the address into slot-index chunks, lowest chunk first
    function automatic slot_t fold_addr(obj_addr_t a);
        slot_t h;
        h = '0;
        for (int i = 0; i < FOLD_CHUNKS; i++) begin
            h = h ^ slot_t'(a >> (i * SLOT_BITS));
        end
        return h;
    endfunction

endpackage

// File: rtl/ort_pick_first.sv
module ort_pick_first #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/ort_slot_table.sv
module ort_slot_table
    import ort_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  obj_addr_t lk_addr,
    output logic      lk_hit,
    output logic      lk_busy,
    output slot_t     lk_slot,
    output ver_t      lk_latest,
    input  logic      upd_en,
    input  ver_t      upd_latest,
    input  logic      inv_en,
    input  slot_t     inv_slot
);

    slot_ent_t ents [NUM_SLOTS];
    slot_ent_t cur;

    always_comb begin
        lk_slot   = fold_addr(lk_addr);
        cur       = ents[lk_slot];
        lk_hit    = cur.live && (cur.tag == lk_addr);
        lk_busy   = cur.live && (cur.tag != lk_addr);
        lk_latest = cur.latest;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                ents[s] <= '0;
            end
        end else begin
            if (inv_en) begin
                ents[inv_slot].live <= 1'b0;
            end
            if (upd_en) begin
                ents[lk_slot].live   <= 1'b1;
                ents[lk_slot].tag    <= lk_addr;
                ents[lk_slot].latest <= upd_latest;
            end
        end
    end

endmodule

// File: rtl/ort_version_table.sv
module ort_version_table
    import ort_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    // allocation of a new version at free_idx
    input  logic     alloc_en,
    input  slot_t    alloc_slot,
    input  task_id_t alloc_task,
    output logic     free_any,
    output ver_t     free_idx,
    // chain link from an older version to the newly allocated one
    input  logic     link_en,
    input  ver_t     link_from,
    // reader accounting and producer completion
    input  logic     rinc_en,
    input  ver_t     rinc_idx,
    input  logic     rdec_en,
    input  ver_t     rdec_idx,
    input  logic     done_en,
    input  ver_t     done_idx,
    // query of one record
    input  ver_t     q_idx,
    output logic     q_done,
    output logic     q_full,
    // release of one version per cycle
    output logic     rel_fire,
    output ver_t     rel_idx,
    output slot_t    rel_slot,
    output logic     rel_no_next,
    // in-order unblock message
    output logic     unb_valid,
    output ver_t     unb_ver,
    output task_id_t unb_task
);

    ver_rec_t              recs   [NUM_VERS];
    rdr_t                  rd_nxt [NUM_VERS];
    logic [NUM_VERS-1:0]   free_vec;
    logic [NUM_VERS-1:0]   rel_vec;

    for (genvar v = 0; v < NUM_VERS; v++) begin : g_ver
        assign free_vec[v] = !recs[v].live;
        assign rel_vec[v]  = recs[v].live && recs[v].done && (recs[v].readers == '0);

        always_comb begin
            rd_nxt[v] = recs[v].readers;
            if (rinc_en && (rinc_idx == ver_t'(v))) begin
                rd_nxt[v] = rd_nxt[v] + rdr_t'(1);
            end
            if (rdec_en && (rdec_idx == ver_t'(v))) begin
                rd_nxt[v] = rd_nxt[v] - rdr_t'(1);
            end
        end
    end

    ort_pick_first #(.N(NUM_VERS), .IW(VER_BITS)) u_free_pick (
        .req (free_vec),
        .any (free_any),
        .idx (free_idx)
    );

    ort_pick_first #(.N(NUM_VERS), .IW(VER_BITS)) u_rel_pick (
        .req (rel_vec),
        .any (rel_fire),
        .idx (rel_idx)
    );

    assign rel_slot    = recs[rel_idx].slot;
    assign rel_no_next = !recs[rel_idx].has_next;
    assign q_done      = recs[q_idx].done;
    assign q_full      = (recs[q_idx].readers == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int v = 0; v < NUM_VERS; v++) begin
                recs[v] <= '0;
            end
            unb_valid <= 1'b0;
            unb_ver   <= '0;
            unb_task  <= '0;
        end else begin
            unb_valid <= 1'b0;
            for (int v = 0; v < NUM_VERS; v++) begin
                recs[v].readers <= rd_nxt[v];
                if (done_en && (done_idx == ver_t'(v))) begin
                    recs[v].done <= 1'b1;
                end
                if (link_en && (link_from == ver_t'(v))) begin
                    recs[v].has_next <= 1'b1;
                    recs[v].next     <= free_idx;
                end
            end
            if (rel_fire) begin
                recs[rel_idx].live <= 1'b0;
                if (recs[rel_idx].has_next) begin
                    unb_valid <= 1'b1;
                    unb_ver   <= recs[rel_idx].next;
                    unb_task  <= recs[recs[rel_idx].next].producer;
                end
            end
            if (alloc_en) begin
                recs[free_idx].live     <= 1'b1;
                recs[free_idx].done     <= 1'b0;
                recs[free_idx].has_next <= 1'b0;
                recs[free_idx].next     <= '0;
                recs[free_idx].slot     <= alloc_slot;
                recs[free_idx].producer <= alloc_task;
                recs[free_idx].readers  <= '0;
            end
        end
    end

endmodule

// File: rtl/task_obj_renamer.sv
module task_obj_renamer
    import ort_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dec_valid,
    output logic                  dec_ready,
    input  logic                  dec_write,
    input  logic [OBJ_ADDR_W-1:0] dec_addr,
    input  logic [TASK_ID_W-1:0]  dec_task,
    output logic                  rsp_valid,
    output logic                  rsp_wait,
    output logic                  rsp_tracked,
    output logic [VER_BITS-1:0]   rsp_dep_ver,
    output logic [VER_BITS-1:0]   rsp_new_ver,
    input  logic                  done_valid,
    input  logic [VER_BITS-1:0]   done_ver,
    input  logic                  rdone_valid,
    input  logic [VER_BITS-1:0]   rdone_ver,
    output logic                  unb_valid,
    output logic [VER_BITS-1:0]   unb_ver,
    output logic [TASK_ID_W-1:0]  unb_task
);

    logic     lk_hit, lk_busy;
    slot_t    lk_slot;
    ver_t     lk_latest;
    logic     q_done, q_full;
    logic     free_any;
    ver_t     free_idx;
    logic     rel_fire, rel_no_next;
    ver_t     rel_idx;
    slot_t    rel_slot;
    logic     rel_clash;
    logic     fire;
    dec_rsp_t rsp_d, rsp_q;
    logic     rsp_v_q;

    ort_slot_table u_slots (
        .clk        (clk),
        .rst        (rst),
        .lk_addr    (dec_addr),
        .lk_hit     (lk_hit),
        .lk_busy    (lk_busy),
        .lk_slot    (lk_slot),
        .lk_latest  (lk_latest),
        .upd_en     (fire && dec_write),
        .upd_latest (free_idx),
        .inv_en     (rel_fire && rel_no_next),
        .inv_slot   (rel_slot)
    );

    ort_version_table u_vers (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (fire && dec_write),
        .alloc_slot  (lk_slot),
        .alloc_task  (dec_task),
        .free_any    (free_any),
        .free_idx    (free_idx),
        .link_en     (fire && dec_write && lk_hit),
        .link_from   (lk_latest),
        .rinc_en     (fire && !dec_write && lk_hit),
        .rinc_idx    (lk_latest),
        .rdec_en     (rdone_valid),
        .rdec_idx    (rdone_ver),
        .done_en     (done_valid),
        .done_idx    (done_ver),
        .q_idx       (lk_latest),
        .q_done      (q_done),
        .q_full      (q_full),
        .rel_fire    (rel_fire),
        .rel_idx     (rel_idx),
        .rel_slot    (rel_slot),
        .rel_no_next (rel_no_next),
        .unb_valid   (unb_valid),
        .unb_ver     (unb_ver),
        .unb_task    (unb_task)
    );

    // A version being freed this cycle must not be linked to or read from
    assign rel_clash = rel_fire && lk_hit && (rel_idx == lk_latest);

    always_comb begin
        if (lk_busy || rel_clash) begin
            dec_ready = 1'b0;
        end else if (dec_write) begin
            dec_ready = free_any;
        end else begin
            dec_ready = !(lk_hit && q_full);
        end
    end

    assign fire = dec_valid && dec_ready;

    always_comb begin
        rsp_d          = '0;
        rsp_d.tracked  = !dec_write && lk_hit;
        rsp_d.wait_dep = dec_write ? lk_hit : (lk_hit && !q_done);
        rsp_d.dep      = lk_hit ? lk_latest : '0;
        rsp_d.new_ver  = dec_write ? free_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_v_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            rsp_v_q <= fire;
            if (fire) begin
                rsp_q <= rsp_d;
            end
        end
    end

    assign rsp_valid   = rsp_v_q;
    assign rsp_wait    = rsp_q.wait_dep;
    assign rsp_tracked = rsp_q.tracked;
    assign rsp_dep_ver = rsp_q.dep;
    assign rsp_new_ver = rsp_q.new_ver;

endmodule

// File: rtl/task_obj_renamer_checker.sv
module task_obj_renamer_checker
    import ort_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic dec_valid,
    input logic dec_ready,
    input logic dec_write,
    input logic rsp_valid,
    input logic unb_valid,
    input ver_t unb_ver,
    input logic lk_busy,
    input logic free_any
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !unb_valid)); // R1

    AST_NO_CONFLICT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready) |-> !lk_busy); // R2

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready) |=> rsp_valid); // R4

    AST_RSP_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !(dec_valid && dec_ready) |=> !rsp_valid); // R4

    AST_UNBLOCK_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        unb_valid |=> (!unb_valid || (unb_ver != $past(unb_ver)))); // R8

    AST_WRITE_NEEDS_FREE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready && dec_write) |-> free_any); // R9

endmodule

bind task_obj_renamer task_obj_renamer_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .dec_ready (dec_ready),
    .dec_write (dec_write),
    .rsp_valid (rsp_valid),
    .unb_valid (unb_valid),
    .unb_ver   (unb_ver),
    .lk_busy   (lk_busy),
    .free_any  (free_any)
);

// File: tb/task_obj_renamer_test.sv
module task_obj_renamer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0;
    logic        dec_ready;
    logic        dec_write = 1'b0;
    logic [31:0] dec_addr = '0;
    logic [7:0]  dec_task = '0;
    logic        rsp_valid, rsp_wait, rsp_tracked;
    logic [3:0]  rsp_dep_ver, rsp_new_ver;
    logic        done_valid = 1'b0;
    logic [3:0]  done_ver = '0;
    logic        rdone_valid = 1'b0;
    logic [3:0]  rdone_ver = '0;
    logic        unb_valid;
    logic [3:0]  unb_ver;
    logic [7:0]  unb_task;

    int n_chk = 0;
    int n_fail = 0;
    int n_unb = 0;
    logic [3:0] last_ver = '0;
    logic [7:0] last_task = '0;
    bit finished = 0;

    always #2 clk = ~clk;

    task_obj_renamer uut (.*);

    // Unblock log, sampled 1 ns after each edge
    always @(posedge clk) begin
        #1;
        if (!rst && unb_valid) begin
            n_unb++;
            last_ver  = unb_ver;
            last_task = unb_task;
        end
    end

    localparam logic [31:0] OA = 32'h0000_0100;
    localparam logic [31:0] OB = 32'h0000_0200;

    typedef struct packed {
        logic [1:0]  op;     // 0 read, 1 write, 2 producer done, 3 reader done
        logic [31:0] addr;
        logic [7:0]  id;     // task for decode, version for events
        logic        w;
        logic        t;
        logic [3:0]  dep;
        logic [3:0]  nv;
        logic [3:0]  un;
        logic [3:0]  uver;
        logic [7:0]  utask;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{2'd0, OA, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 8'd0},
        '{2'd1, OA, 8'd1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 8'd0},
        '{2'd0, OA, 8'd0, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0, 8'd0},
        '{2'd1, OA, 8'd2, 1'b1, 1'b0, 4'd0, 4'd1, 4'd0, 4'd0, 8'd0},
        '{2'd0, OA, 8'd0, 1'b1, 1'b1, 4'd1, 4'd0, 4'd0, 4'd0, 8'd0},
        '{2'd1, OB, 8'd3, 1'b0, 1'b0, 4'd0, 4'd2, 4'd0, 4'd0, 8'd0},
        '{2'd2, 32'd0, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 8'd0},
        '{2'd3, 32'd0, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd0, OA, 8'd0, 1'b1, 1'b1, 4'd1, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd2, 32'd0, 8'd1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd3, 32'd0, 8'd1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd3, 32'd0, 8'd1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd0, OA, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd2, 32'd0, 8'd2, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd0, OB, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd1, OA, 8'd4, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd0, OA, 8'd0, 1'b1, 1'b1, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd2, 32'd0, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd0, OA, 8'd0, 1'b0, 1'b1, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd1, OA, 8'd5, 1'b1, 1'b0, 4'd0, 4'd1, 4'd1, 4'd1, 8'd2},
        '{2'd1, OA, 8'd6, 1'b1, 1'b0, 4'd1, 4'd2, 4'd1, 4'd1, 8'd2},
        '{2'd3, 32'd0, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 8'd2},
        '{2'd3, 32'd0, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd2, 4'd1, 8'd5},
        '{2'd2, 32'd0, 8'd1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd3, 4'd2, 8'd6},
        '{2'd2, 32'd0, 8'd2, 1'b0, 1'b0, 4'd0, 4'd0, 4'd3, 4'd2, 8'd6},
        '{2'd0, OA, 8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd3, 4'd2, 8'd6}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Offer one operand from a negedge; return after its response is visible
    task automatic do_dec(input logic wr, input logic [31:0] a, input logic [7:0] tk);
        dec_write = wr;
        dec_addr  = a;
        dec_task  = tk;
        dec_valid = 1'b1;
        #1;
        while (!dec_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic do_evt(input logic is_done, input logic [3:0] v);
        if (is_done) begin
            done_valid = 1'b1;
            done_ver   = v;
        end else begin
            rdone_valid = 1'b1;
            rdone_ver   = v;
        end
        @(negedge clk);
        done_valid  = 1'b0;
        rdone_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "dec_ready", int'(dec_ready), 1);
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "unb_valid", int'(unb_valid), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].op <= 2'd1) begin
                do_dec(TBL[i].op[0], TBL[i].addr, TBL[i].id);
                chk("R4", "rsp_valid", int'(rsp_valid), 1);
                if (TBL[i].op == 2'd1) begin
                    chk("R5", "write wait", int'(rsp_wait), int'(TBL[i].w));
                    chk("R5", "write dep", int'(rsp_dep_ver), int'(TBL[i].dep));
                    chk("R5", "new version", int'(rsp_new_ver), int'(TBL[i].nv));
                end else if (!TBL[i].t) begin
                    chk("R3", "untracked wait", int'(rsp_wait), 0);
                    chk("R3", "untracked flag", int'(rsp_tracked), 0);
                end else begin
                    chk("R4", "read wait", int'(rsp_wait), int'(TBL[i].w));
                    chk("R4", "read tracked", int'(rsp_tracked), 1);
                    chk("R4", "read dep", int'(rsp_dep_ver), int'(TBL[i].dep));
                end
            end else begin
                do_evt(TBL[i].op == 2'd2, TBL[i].id[3:0]);
                chk("R7", "unblock count", n_unb, int'(TBL[i].un));
                if (TBL[i].un != 0) begin
                    chk("R8", "unblock version", int'(last_ver), int'(TBL[i].uver));
                    chk("R8", "unblock task", int'(last_task), int'(TBL[i].utask));
                end
            end
        end

        // R2: slot conflict across the top fold chunk (0x80000000 and 2 share slot 2)
        do_dec(1'b1, 32'h8000_0000, 8'd7);
        chk("R2", "first write version", int'(rsp_new_ver), 0);
        dec_write = 1'b1;
        dec_addr  = 32'd2;
        dec_task  = 8'd8;
        dec_valid = 1'b1;
        #1;
        chk("R2", "conflict ready", int'(dec_ready), 0);
        @(negedge clk);
        chk("R2", "conflict not accepted", int'(rsp_valid), 0);
        dec_valid = 1'b0;
        do_evt(1'b1, 4'd0);
        do_dec(1'b1, 32'd2, 8'd8);
        chk("R2", "accepted after free wait", int'(rsp_wait), 0);
        chk("R7", "reuse of freed version", int'(rsp_new_ver), 0);
        do_evt(1'b1, 4'd0);

        // R9: exhaust all versions
        for (int k = 0; k < 16; k++) begin
            do_dec(1'b1, 32'(10 + k), 8'(k));
            chk("R9", "fill version", int'(rsp_new_ver), k);
        end
        dec_write = 1'b1;
        dec_addr  = 32'd40;
        dec_valid = 1'b1;
        #1;
        chk("R9", "write stalls when full", int'(dec_ready), 0);
        dec_valid = 1'b0;
        do_dec(1'b0, 32'd41, 8'd0);
        chk("R9", "read accepted when full", int'(rsp_wait), 0);
        for (int k = 0; k < 16; k++) begin
            do_evt(1'b1, 4'(k));
        end
        do_dec(1'b1, 32'd50, 8'd9);
        chk("R7", "all versions freed", int'(rsp_new_ver), 0);

        // R10: reader count saturation on version 0
        for (int k = 0; k < 15; k++) begin
            do_dec(1'b0, 32'd50, 8'd0);
        end
        chk("R10", "15th read dep", int'(rsp_dep_ver), 0);
        dec_write = 1'b0;
        dec_addr  = 32'd50;
        dec_valid = 1'b1;
        #1;
        chk("R10", "read stalls at max readers", int'(dec_ready), 0);
        dec_valid = 1'b0;
        do_evt(1'b0, 4'd0);
        do_dec(1'b0, 32'd50, 8'd0);
        chk("R10", "read accepted after one reader done", int'(rsp_tracked), 1);

        // R6: write then read of a new object in back-to-back cycles
        do_dec(1'b1, 32'd60, 8'd11);
        chk("R6", "write version", int'(rsp_new_ver), 1);
        do_dec(1'b0, 32'd60, 8'd12);
        chk("R6", "read sees prior write", int'(rsp_dep_ver), 1);
        chk("R6", "read waits on prior write", int'(rsp_wait), 1);

        summary();
    end

endmodule